// File: doc/BRIEF.md
# Voltage Monitor Interrupt Controller

This block is the digital side of a supply and pin voltage supervisor. An analog comparator, outside the block, compares either the supply against one of three internal levels or an external pin against a fixed reference, and hands its one-bit verdict to this block without any clock relationship. The block resynchronises that verdict, filters out short glitches, and publishes the result as a status bit that reads 1 when the supervised voltage is above the chosen level and 0 when it is below.

Software programs a 4-bit control register. Its upper three bits pick the source and threshold, which the block drives to the analog side as an enable, a pin-versus-supply select and a two-bit level select. The same code also fixes the polarity of the status change that counts as an event. The lowest bit is an active-low interrupt mask. An event sets a sticky pending flag. The interrupt line shows that flag while the mask bit is 0, and any write to the control register clears the flag.

Top module: `vmon_irq_ctrl`

## Requirements
- R1: While rst_n is 0 at a clock edge, the block clears ctrl_o to 4'b0000, stat_o to 4'b0000, irq_o, mon_en_o and ext_sel_o to 0, and lvl_sel_o to 2'd0.
- R2: When wr_en_i is 1 at a clock edge, that edge loads wr_data_i into the control register, and ctrl_o returns the value from then on. Bits [3:1] hold the mode code and bit 0 holds the mask.
- R3: The mode code selects the analog settings. 3'b000 turns the monitor off (mon_en_o=0). Code x01 selects the external pin (ext_sel_o=1). Code x10 selects the low supply level (lvl_sel_o=2'd0). Code x11 selects the middle level (lvl_sel_o=2'd1). Code 100 selects the high level (lvl_sel_o=2'd2). In pin mode and in off mode, lvl_sel_o is 2'd0.
- R4: stat_o is {3'b000, vms}. Bits 3:1 always read 0. Bit 0 (vms) is 1 when the filtered comparator reports the voltage above the threshold.
- R5: vms takes a new comparator level at the 6th rising clock edge after cmp_async_i changes: two synchroniser stages, then 4 consecutive samples that differ from vms. A level that reaches the synchroniser output for fewer than 4 cycles leaves vms unchanged.
- R6: While the mode code is 3'b000, vms is held at 0, the filter restarts, and no event is raised. This includes the fall of vms caused by switching the monitor off.
- R7: Codes 001, 010, 011 and 100 raise an event when vms rises (0 to 1). Codes 101, 110 and 111 raise an event when vms falls (1 to 0).
- R8: An event sets the pending flag at the same edge at which vms changes. irq_o is 1 exactly when the flag is set and ctrl_o[0] is 0.
- R9: A control write clears the pending flag at its edge. When an event occurs at that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_async_i | input | 1 | Comparator output, asynchronous |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 4 | Control write data: {mode[2:0], mask} |
| ctrl_o | output | 4 | Control register readback |
| stat_o | output | 4 | Status register: {3'b000, vms} |
| mon_en_o | output | 1 | Enable to the analog comparator |
| ext_sel_o | output | 1 | 1 selects the external pin, 0 the supply |
| lvl_sel_o | output | 2 | Supply level: 0 low, 1 middle, 2 high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A control write shows on ctrl_o and on the analog selects one edge after the strobe, and it clears the pending flag at that same edge. A comparator change reaches stat_o at the sixth edge, and any resulting interrupt appears at that same edge. The bench drives inputs on the falling clock edge and samples on the next falling edge. A cycle-by-cycle reference, written from the requirements, advances at each rising edge so that every comparison falls after exactly the edges that matter. Directed runs count edges explicitly: they check that stat_o still reads 0 after the fifth edge and reads 1 after the sixth, that a three-cycle pulse is rejected, and that a write and an event at the same edge leave the flag set.

// File: rtl/vmon_pkg.sv
// Package: shared types and the mode decoder for the voltage monitor.
// Assumes a 3-bit mode code in control bits [3:1] and the mask in bit 0.
package vmon_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } vmon_lvl_e;

    typedef struct packed {
        logic      en;     // comparator active
        logic      ext;    // external pin selected
        vmon_lvl_e lvl;    // supply level
        logic      fall;   // events on the falling change of vms
    } vmon_cfg_t;

    localparam int CTRL_W = 4;
    localparam int MODE_W = 3;

    // Turn a mode code into the analog settings and the event polarity.
    function automatic vmon_cfg_t vmon_decode(input logic [MODE_W-1:0] mode);
        vmon_cfg_t c;
        c.en   = 1'b1;
        c.ext  = 1'b0;
        c.lvl  = LVL_LOW;
        c.fall = mode[2];
        unique case (mode[1:0])
            2'b00: begin
                if (mode[2]) begin
                    c.lvl  = LVL_HIGH;
                    c.fall = 1'b0;
                end else begin
                    c.en   = 1'b0;
                    c.fall = 1'b0;
                end
            end
            2'b01: c.ext = 1'b1;
            2'b10: c.lvl = LVL_LOW;
            2'b11: c.lvl = LVL_MID;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vmon_sync.sv
// Module: multi-stage synchroniser for one asynchronous bit.
// Assumes STAGES >= 2. The output lags the input by STAGES clock edges.
module vmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/vmon_filter.sv
// Module: glitch filter that turns the synchronised comparator into vms.
// Assumes smp_i is already synchronous. vms takes a new level after DEB_LEN
// consecutive samples that differ from it. It is forced to 0 while en_i is low.
module vmon_filter #(
    parameter int DEB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic smp_i,
    output logic vms_o,
    output logic chg_o
);
    localparam int CNT_W = $clog2(DEB_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

    logic             vms_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differ;

    assign differ = en_i && (smp_i != vms_q);
    assign chg_o  = differ && (cnt_q == CNT_LAST);
    assign vms_o  = vms_q;

    // Count differing samples and adopt the new level once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            vms_q <= 1'b0;
            cnt_q <= '0;
        end else if (chg_o) begin
            vms_q <= smp_i;
            cnt_q <= '0;
        end else if (differ) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R6: while the monitor is off, vms stays at 0.
    a_r6_off_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !vms_o);

    // R5: vms changes only after a full run of differing samples.
    a_r5_full_run_before_change: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (smp_i != vms_q) && (cnt_q != CNT_LAST)) |=> (vms_q == $past(vms_q)));

endmodule

// File: rtl/vmon_ctrl_regs.sv
// Module: control register and mode decode for the voltage monitor.
// Assumes a single write strobe. A write takes effect at the edge where the strobe is high.
module vmon_ctrl_regs
    import vmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output vmon_cfg_t         cfg_o,
    output logic              mask_o
);
    logic [CTRL_W-1:0] ctrl_q;

    // Hold the control value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_en_i) ctrl_q <= wr_data_i;
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = ctrl_q[0];
    assign cfg_o  = vmon_decode(ctrl_q[CTRL_W-1:1]);

    // R2: a write is visible on the readback one edge later.
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ctrl_o == $past(wr_data_i)));

    // R3: the high level is only ever driven with the monitor on and the pin deselected.
    a_r3_high_supply_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o.lvl == LVL_HIGH) |-> (cfg_o.en && !cfg_o.ext));

endmodule

// File: rtl/vmon_event.sv
// Module: edge qualification and the sticky pending flag for the interrupt.
// Assumes chg_i pulses for one cycle at the edge where vms takes new_i.
module vmon_event (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic new_i,
    input  logic fall_i,
    input  logic wr_i,
    input  logic mask_i,
    output logic irq_o
);
    logic pend_q;
    logic qual;

    assign qual = chg_i && (fall_i ? !new_i : new_i);

    // Set on a qualifying change; a control write clears, but a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= 1'b0;
        else if (qual) pend_q <= 1'b1;
        else if (wr_i) pend_q <= 1'b0;
    end

    assign irq_o = pend_q && !mask_i;

    // R8: a qualifying change leaves the flag set.
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> pend_q);

    // R9: a write without an event clears the flag.
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !qual) |=> !pend_q);

    // R8: the flag holds until a write.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wr_i) |=> pend_q);

endmodule

// File: rtl/vmon_irq_ctrl.sv
// Module: top of the voltage monitor interrupt controller.
// Assumes cmp_async_i comes from an analog comparator with no clock relation.
// Joins the control register, the synchroniser, the glitch filter and the event logic.
module vmon_irq_ctrl
    import vmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_async_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_data_i,
    output logic [3:0] ctrl_o,
    output logic [3:0] stat_o,
    output logic       mon_en_o,
    output logic       ext_sel_o,
    output logic [1:0] lvl_sel_o,
    output logic       irq_o
);
    vmon_cfg_t cfg;
    logic      mask;
    logic      cmp_sync;
    logic      vms;
    logic      chg;

    vmon_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl_o),
        .cfg_o     (cfg),
        .mask_o    (mask)
    );

    vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_async_i),
        .q_o   (cmp_sync)
    );

    vmon_filter #(.DEB_LEN(DEB_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cfg.en),
        .smp_i (cmp_sync),
        .vms_o (vms),
        .chg_o (chg)
    );

    vmon_event u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg),
        .new_i  (cmp_sync),
        .fall_i (cfg.fall),
        .wr_i   (wr_en_i),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    assign stat_o    = {3'b000, vms};
    assign mon_en_o  = cfg.en;
    assign ext_sel_o = cfg.ext;
    assign lvl_sel_o = cfg.lvl;

    // R8: with the mask bit set, the interrupt line stays low.
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[0] |-> !irq_o);

    // R6: with the monitor off, no interrupt can newly appear without a write.
    a_r6_off_no_new_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en_o && !irq_o && !wr_en_i) |=> !irq_o);

endmodule

// File: tb/vmon_irq_ctrl_test.sv
module vmon_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] ctrl_o, stat_o;
    logic       mon_en_o, ext_sel_o, irq_o;
    logic [1:0] lvl_sel_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmon_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .ctrl_o(ctrl_o), .stat_o(stat_o),
        .mon_en_o(mon_en_o), .ext_sel_o(ext_sel_o), .lvl_sel_o(lvl_sel_o),
        .irq_o(irq_o)
    );

    // Reference state, written from the requirements.
    logic [3:0] m_ctrl;
    logic       m_s1, m_s2, m_vms, m_pend;
    int         m_cnt;

    function automatic bit f_en(input logic [2:0] m);
        return m != 3'b000;
    endfunction
    function automatic bit f_ext(input logic [2:0] m);
        return m[1:0] == 2'b01;
    endfunction
    function automatic logic [1:0] f_lvl(input logic [2:0] m);
        if (m == 3'b100) return 2'd2;
        if (m[1:0] == 2'b11) return 2'd1;
        return 2'd0;
    endfunction
    function automatic bit f_fall(input logic [2:0] m);
        return m[2] && (m[1:0] != 2'b00);
    endfunction

    always @(posedge clk) begin
        bit upd;
        upd = 1'b0;
        if (!rst_n) begin
            m_ctrl <= 4'h0; m_s1 <= 1'b0; m_s2 <= 1'b0;
            m_vms <= 1'b0; m_pend <= 1'b0; m_cnt <= 0;
        end else begin
            m_s1 <= cmp;
            m_s2 <= m_s1;
            if (wr_en) m_ctrl <= wr_data;
            if (!f_en(m_ctrl[3:1])) begin
                m_vms <= 1'b0; m_cnt <= 0;
            end else if (m_s2 != m_vms) begin
                if (m_cnt == 3) begin
                    m_vms <= m_s2; m_cnt <= 0; upd = 1'b1;
                end else m_cnt <= m_cnt + 1;
            end else m_cnt <= 0;
            if (upd && (f_fall(m_ctrl[3:1]) ? !m_s2 : m_s2)) m_pend <= 1'b1;
            else if (wr_en) m_pend <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference.
    task automatic cmp_all();
        chk(ctrl_o == m_ctrl, "R2 ctrl readback", ctrl_o, m_ctrl);
        chk(stat_o == {3'b000, m_vms}, "R4/R5 status", stat_o, {3'b000, m_vms});
        chk(mon_en_o == f_en(m_ctrl[3:1]), "R3 mon_en", mon_en_o, f_en(m_ctrl[3:1]));
        chk(ext_sel_o == f_ext(m_ctrl[3:1]), "R3 ext_sel", ext_sel_o, f_ext(m_ctrl[3:1]));
        chk(lvl_sel_o == f_lvl(m_ctrl[3:1]), "R3 lvl_sel", lvl_sel_o, f_lvl(m_ctrl[3:1]));
        chk(irq_o == (m_pend && !m_ctrl[0]), "R8 irq", irq_o, m_pend && !m_ctrl[0]);
    endtask

    task automatic step();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(input logic [3:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(ctrl_o == 4'h0, "R1 ctrl reset", ctrl_o, 0);
        chk(stat_o == 4'h0, "R1 stat reset", stat_o, 0);
        chk(irq_o == 1'b0 && mon_en_o == 1'b0 && ext_sel_o == 1'b0 && lvl_sel_o == 2'd0,
            "R1 outputs reset", {irq_o, mon_en_o, ext_sel_o, lvl_sel_o}, 0);
        rst_n = 1'b1;
        step();

        // R5: exact latency on the low level, rising polarity, unmasked.
        wr(4'b0100);
        repeat (8) step();
        cmp = 1'b1;
        repeat (5) step();
        chk(stat_o[0] == 1'b0, "R5 not yet after 5 edges", stat_o[0], 0);
        chk(irq_o == 1'b0, "R8 irq not yet", irq_o, 0);
        step();
        chk(stat_o[0] == 1'b1, "R5 set at 6th edge", stat_o[0], 1);
        chk(irq_o == 1'b1, "R7/R8 rising event raises irq", irq_o, 1);

        // R9: a write clears the flag.
        wr(4'b0100);
        chk(irq_o == 1'b0, "R9 write clears", irq_o, 0);

        // R5: a three-cycle dip is rejected.
        cmp = 1'b0;
        repeat (3) step();
        cmp = 1'b1;
        repeat (10) step();
        chk(stat_o[0] == 1'b1, "R5 short pulse ignored", stat_o[0], 1);

        // R7: falling polarity on code 110; a rise raises nothing.
        wr(4'b1100);
        cmp = 1'b0;
        repeat (6) step();
        chk(irq_o == 1'b1, "R7 falling event", irq_o, 1);
        wr(4'b1100);
        cmp = 1'b1;
        repeat (8) step();
        chk(irq_o == 1'b0 && stat_o[0] == 1'b1, "R7 rise ignored when falling", irq_o, 0);

        // R9: a write at the event edge keeps the flag.
        cmp = 1'b0;
        repeat (5) step();
        wr(4'b1100);
        chk(irq_o == 1'b1, "R9 event wins over write", irq_o, 1);

        // R6: off mode forces vms to 0 and raises nothing.
        wr(4'b1000);
        repeat (8) step();
        cmp = 1'b1;
        repeat (8) step();
        wr(4'b0000);
        step();
        chk(stat_o[0] == 1'b0 && irq_o == 1'b0, "R6 off holds zero", stat_o, 0);
        cmp = 1'b0;
        repeat (8) step();
        chk(irq_o == 1'b0, "R6 no event while off", irq_o, 0);

        // R8: masked event keeps irq low.
        wr(4'b0111);
        cmp = 1'b1;
        repeat (8) step();
        chk(stat_o[0] == 1'b1 && irq_o == 1'b0, "R8 mask blocks irq", irq_o, 0);

        // Random phase checked against the reference every cycle.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                wr_en = 1'b1; wr_data = 4'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 5) == 0) cmp = ~cmp;
            step();
            wr_en = 1'b0;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule